// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block sits behind a 32-bit I/O register window. It records hotplug activity for a set of buses, each with up to 32 slots. Hardware reports slot events on a small event port, which carries a bus index, a slot number, the direction (insert or remove) and a flag for devices that are already present at power-up. Every accepted event sets one bit in that bus's insertion or removal word and pulses a general-purpose event interrupt for firmware.

Firmware selects a bus through a select register and then reads three words for it: pending insertions, pending removals and the mask of removable slots. To request an eject, firmware writes a slot mask. The block serves the lowest set bit of that mask, clears the slot's pending bits and emits a one-cycle release pulse naming the bus and slot. A separate block-reset input starts a drain. The drain ejects every pending removal one slot per cycle and then rebuilds the removable masks from a static per-slot "fixed" map. A legacy mode keeps insertion bits across reads and removes the select register.

Top module: `hotplug_status_bank`

## Requirements
- R1: `regReady` is low during `rstN` and until the drain and the mask rebuild that follow a reset have finished. A register access made while `regReady` is low has no effect. After `rstN` all status words, the select register and `regRdata` are zero.
- R2: An event with `evtValid` high, `evtAtBoot` low and `evtBus` below the bus count sets bit `evtSlot` of that bus's removal word when `evtUnplug` is 1, and of its insertion word when `evtUnplug` is 0. `gpePulse` is then high for exactly the next cycle. A boot-flagged event or an out-of-range bus changes nothing and gives no pulse.
- R3: A read of offset 0x00 returns the selected bus's insertion word on `regRdata` after the next clock edge and clears that word at the same edge.
- R4: A read of offset 0x04 returns the removal word and leaves it unchanged. Offset 0x08 always reads zero. Offset 0x0C returns the removable mask.
- R5: A write to 0x10 loads the 32-bit select register, and a read of 0x10 returns it. While the select value is not below the bus count, every read returns zero and eject writes do nothing.
- R6: A write to 0x08 with nonzero data takes the lowest set bit as the slot and clears that slot's insertion and removal bits on the selected bus. In the next cycle `releaseValid` pulses with `releaseBus` and `releaseSlot`, unless the slot is marked in `fixedSlots` (bit bus*32+slot). Writing zero does nothing.
- R7: After `blockReset`, the block clears one pending removal per cycle, lowest bus first and lowest slot first within a bus, with the same release rule as R6. Once no removal is left, each removable mask becomes the inverse of that bus's `fixedSlots` word.
- R8: If an event sets a bit in the same cycle as an eject, drain or clearing read would clear it, the bit ends up set.
- R9: With `legacyMode` high, bus 0 is always the selected bus and reads of 0x00 do not clear. Offset 0x10 reads zero and ignores writes.
- R10: An access to an address that is not a multiple of 4, or is outside the map, reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blockReset | input | 1 | Starts a removal drain and mask rebuild |
| legacyMode | input | 1 | Legacy behaviour (R9) |
| fixedSlots | input | NUM_BUS*32 | Non-removable slot map, bit bus*32+slot |
| evtValid | input | 1 | Event strobe |
| evtBus | input | 4 | Event bus index |
| evtSlot | input | 5 | Event slot number |
| evtUnplug | input | 1 | 1 = removal, 0 = insertion |
| evtAtBoot | input | 1 | Device present at power-up; event dropped |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte offset within the window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after `regRd` |
| regReady | output | 1 | High when register accesses are accepted |
| gpePulse | output | 1 | One-cycle general-purpose event interrupt |
| releaseValid | output | 1 | One-cycle slot release pulse |
| releaseBus | output | 4 | Bus of the released slot |
| releaseSlot | output | 5 | Released slot |

## Verification
A wrong status bit in this block stays hidden until firmware reads that bus. At that point it shows up on `regRdata` one cycle after the read, or it comes out as a missing or extra release pulse during an eject or a drain. An error in the drain order shows up at once as a release pulse on the wrong bus or slot. An error in the select, legacy or alignment decode shows up as a nonzero read that should be zero. For these reasons the bench compares `regRdata`, `regReady`, `gpePulse` and the release outputs with its model on every clock. It does not wait for the final readback.

// File: rtl/hpbank_pkg.sv
package hpbank_pkg;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 5;
  localparam int BUS_IDX_W = 4;

  localparam int OFS_INSERT = 'h00;
  localparam int OFS_REMOVE = 'h04;
  localparam int OFS_EJECT  = 'h08;
  localparam int OFS_MASK   = 'h0C;
  localparam int OFS_SELECT = 'h10;

  typedef enum logic [1:0] {ST_DRAIN, ST_REBUILD, ST_IDLE} hpState_e;
  typedef enum logic [2:0] {RD_ZERO, RD_INSERT, RD_REMOVE, RD_MASK, RD_SELECT} hpRdSrc_e;

  typedef struct packed {
    logic                 setEn;
    logic                 setDown;
    logic [BUS_IDX_W-1:0] setBus;
    logic [SLOT_W-1:0]    setSlot;
    logic                 clrEn;
    logic [BUS_IDX_W-1:0] clrBus;
    logic [SLOT_W-1:0]    clrSlot;
    logic                 rdEn;
    hpRdSrc_e             rdSrc;
    logic [BUS_IDX_W-1:0] rdBus;
    logic                 upRdClr;
    logic                 selLoad;
    logic                 maskLoad;
  } hpStrobe_t;

  function automatic logic [SLOT_W-1:0] lowestSetBit(input logic [DATA_W-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hpbank_ctrl.sv
module hpbank_ctrl
  import hpbank_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      blockReset,
  input  logic                      legacyMode,
  input  logic                      evtValid,
  input  logic [BUS_IDX_W-1:0]      evtBus,
  input  logic [SLOT_W-1:0]         evtSlot,
  input  logic                      evtUnplug,
  input  logic                      evtAtBoot,
  input  logic                      regRd,
  input  logic                      regWr,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWdata,
  input  logic [DATA_W-1:0]         selQ,
  input  logic [NUM_BUS*DATA_W-1:0] downFlat,
  output hpStrobe_t                 strobe,
  output logic                      regReady
);
  localparam logic [ADDR_W-1:0] A_INSERT = ADDR_W'(OFS_INSERT);
  localparam logic [ADDR_W-1:0] A_REMOVE = ADDR_W'(OFS_REMOVE);
  localparam logic [ADDR_W-1:0] A_EJECT  = ADDR_W'(OFS_EJECT);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SELECT = ADDR_W'(OFS_SELECT);
  localparam logic [DATA_W-1:0] BUS_LIMIT = DATA_W'(NUM_BUS);
  localparam logic [BUS_IDX_W:0] EVT_LIMIT = (BUS_IDX_W+1)'(NUM_BUS);

  hpState_e stateQ, stateD;
  logic [BUS_IDX_W-1:0] effBus, drainBus;
  logic [DATA_W-1:0] drainWord;
  logic inRange, aligned, drainAny, access;

  assign effBus   = legacyMode ? '0 : selQ[BUS_IDX_W-1:0];
  assign inRange  = legacyMode || (selQ < BUS_LIMIT);
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign access   = (stateQ == ST_IDLE);
  assign regReady = access;

  always_comb begin
    drainAny  = 1'b0;
    drainBus  = '0;
    drainWord = '0;
    for (int b = NUM_BUS - 1; b >= 0; b--) begin
      if (downFlat[b*DATA_W +: DATA_W] != '0) begin
        drainAny  = 1'b1;
        drainBus  = BUS_IDX_W'(b);
        drainWord = downFlat[b*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.setEn   = evtValid && !evtAtBoot && ({1'b0, evtBus} < EVT_LIMIT);
    strobe.setDown = evtUnplug;
    strobe.setBus  = evtBus;
    strobe.setSlot = evtSlot;
    strobe.rdEn    = access && regRd;
    strobe.rdBus   = effBus;
    strobe.rdSrc   = RD_ZERO;
    if (aligned && inRange) begin
      case (regAddr)
        A_INSERT: strobe.rdSrc = RD_INSERT;
        A_REMOVE: strobe.rdSrc = RD_REMOVE;
        A_MASK:   strobe.rdSrc = RD_MASK;
        A_SELECT: strobe.rdSrc = legacyMode ? RD_ZERO : RD_SELECT;
        default:  strobe.rdSrc = RD_ZERO;
      endcase
    end
    strobe.upRdClr  = strobe.rdEn && inRange && !legacyMode && (regAddr == A_INSERT);
    strobe.selLoad  = access && regWr && !legacyMode && (regAddr == A_SELECT);
    strobe.maskLoad = (stateQ == ST_REBUILD);
    if (stateQ == ST_DRAIN) begin
      strobe.clrEn   = drainAny;
      strobe.clrBus  = drainBus;
      strobe.clrSlot = lowestSetBit(drainWord);
    end else if (access && regWr && (regAddr == A_EJECT) && inRange && (regWdata != '0)) begin
      strobe.clrEn   = 1'b1;
      strobe.clrBus  = effBus;
      strobe.clrSlot = lowestSetBit(regWdata);
    end
  end

  always_comb begin
    stateD = stateQ;
    if (blockReset) stateD = ST_DRAIN;
    else begin
      case (stateQ)
        ST_DRAIN:   if (!drainAny) stateD = ST_REBUILD;
        ST_REBUILD: stateD = ST_IDLE;
        default:    stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_DRAIN;
    else       stateQ <= stateD;
  end

  // R1: nothing can move the select register while accesses are held off
  assert_held_off_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    !regReady |=> $stable(selQ));
endmodule

// File: rtl/hpbank_datapath.sv
module hpbank_datapath
  import hpbank_pkg::*;
#(
  parameter int NUM_BUS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hpStrobe_t                 strobe,
  input  logic [NUM_BUS*DATA_W-1:0] fixedSlots,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         selQ,
  output logic [NUM_BUS*DATA_W-1:0] downFlat,
  output logic [DATA_W-1:0]         regRdata,
  output logic                      gpePulse,
  output logic                      releaseValid,
  output logic [BUS_IDX_W-1:0]      releaseBus,
  output logic [SLOT_W-1:0]         releaseSlot
);
  logic [NUM_BUS*DATA_W-1:0] busRd;
  logic [NUM_BUS-1:0] fixedHit;
  logic [DATA_W-1:0] rdWord;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    localparam logic [BUS_IDX_W-1:0] BUS_ID = BUS_IDX_W'(b);
    logic [DATA_W-1:0] upQ, downQ, maskQ, fixedWord;
    logic [DATA_W-1:0] setUp, setDown, clrBit, rdClr;

    assign fixedWord = fixedSlots[b*DATA_W +: DATA_W];
    assign setUp   = (strobe.setEn && !strobe.setDown && strobe.setBus == BUS_ID) ? (DATA_W'(1) << strobe.setSlot) : '0;
    assign setDown = (strobe.setEn &&  strobe.setDown && strobe.setBus == BUS_ID) ? (DATA_W'(1) << strobe.setSlot) : '0;
    assign clrBit  = (strobe.clrEn && strobe.clrBus == BUS_ID) ? (DATA_W'(1) << strobe.clrSlot) : '0;
    assign rdClr   = (strobe.upRdClr && strobe.rdBus == BUS_ID) ? '1 : '0;
    assign fixedHit[b] = (strobe.clrBus == BUS_ID) && fixedWord[strobe.clrSlot];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upQ   <= '0;
        downQ <= '0;
        maskQ <= '0;
      end else begin
        upQ   <= (upQ & ~clrBit & ~rdClr) | setUp;
        downQ <= (downQ & ~clrBit) | setDown;
        if (strobe.maskLoad) maskQ <= ~fixedWord;
      end
    end

    assign downFlat[b*DATA_W +: DATA_W] = downQ;
    assign busRd[b*DATA_W +: DATA_W] =
      (strobe.rdBus != BUS_ID)         ? '0    :
      (strobe.rdSrc == RD_INSERT)      ? upQ   :
      (strobe.rdSrc == RD_REMOVE)      ? downQ :
      (strobe.rdSrc == RD_MASK)        ? maskQ : '0;

    // R3: a clearing read with no insertion arriving leaves the word empty
    assert_read_empties_insert_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.upRdClr && strobe.rdBus == BUS_ID && setUp == '0) |=> (upQ == '0));
    // R8: a removal event on the slot being ejected survives the eject
    assert_event_beats_eject_R8: assert property (@(posedge clk) disable iff (!rstN)
      (setDown != '0 && clrBit == setDown) |=> ((downQ & $past(setDown)) != '0));
  end

  always_comb begin
    rdWord = '0;
    for (int b = 0; b < NUM_BUS; b++) rdWord = rdWord | busRd[b*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ         <= '0;
      regRdata     <= '0;
      gpePulse     <= 1'b0;
      releaseValid <= 1'b0;
      releaseBus   <= '0;
      releaseSlot  <= '0;
    end else begin
      if (strobe.selLoad) selQ <= regWdata;
      if (strobe.rdEn) regRdata <= (strobe.rdSrc == RD_SELECT) ? selQ : rdWord;
      gpePulse     <= strobe.setEn;
      releaseValid <= strobe.clrEn && !(|fixedHit);
      releaseBus   <= strobe.clrBus;
      releaseSlot  <= strobe.clrSlot;
    end
  end
endmodule

// File: rtl/hotplug_status_bank.sv
module hotplug_status_bank
  import hpbank_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      blockReset,
  input  logic                      legacyMode,
  input  logic [NUM_BUS*32-1:0]     fixedSlots,
  input  logic                      evtValid,
  input  logic [3:0]                evtBus,
  input  logic [4:0]                evtSlot,
  input  logic                      evtUnplug,
  input  logic                      evtAtBoot,
  input  logic                      regRd,
  input  logic                      regWr,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  output logic                      regReady,
  output logic                      gpePulse,
  output logic                      releaseValid,
  output logic [3:0]                releaseBus,
  output logic [4:0]                releaseSlot
);
  localparam logic [4:0]  EVT_LIMIT = 5'(NUM_BUS);
  localparam logic [31:0] SEL_LIMIT = 32'(NUM_BUS);
  localparam logic [ADDR_W-1:0] A_EJECT = ADDR_W'(OFS_EJECT);

  hpStrobe_t strobe;
  logic [DATA_W-1:0] selQ;
  logic [NUM_BUS*DATA_W-1:0] downFlat;

  hpbank_ctrl #(.NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .blockReset(blockReset), .legacyMode(legacyMode),
    .evtValid(evtValid), .evtBus(evtBus), .evtSlot(evtSlot),
    .evtUnplug(evtUnplug), .evtAtBoot(evtAtBoot),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .selQ(selQ), .downFlat(downFlat), .strobe(strobe), .regReady(regReady)
  );

  hpbank_datapath #(.NUM_BUS(NUM_BUS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fixedSlots(fixedSlots),
    .regWdata(regWdata), .selQ(selQ), .downFlat(downFlat), .regRdata(regRdata),
    .gpePulse(gpePulse), .releaseValid(releaseValid),
    .releaseBus(releaseBus), .releaseSlot(releaseSlot)
  );

  assert_gpe_after_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtAtBoot && ({1'b0, evtBus} < EVT_LIMIT)) |=> gpePulse);
  assert_oor_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regReady && !legacyMode && selQ >= SEL_LIMIT) |=> (regRdata == '0));
  assert_zero_eject_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regReady && regAddr == A_EJECT && regWdata == '0) |=> !releaseValid);
endmodule

// File: tb/hotplug_status_bank_tb_top.sv
module hotplug_status_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam logic [NB*32-1:0] FIXED = {32'h0, 32'h0, 32'h8000_0000, 32'h0000_0008};

  logic clk = 1'b0, rstN = 1'b0, blockReset = 1'b0, legacyMode = 1'b0;
  logic evtValid = 1'b0, evtUnplug = 1'b0, evtAtBoot = 1'b0;
  logic [3:0] evtBus = '0;
  logic [4:0] evtSlot = '0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic regReady, gpePulse, releaseValid;
  logic [3:0] releaseBus;
  logic [4:0] releaseSlot;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int relLog[$];
  bit logRel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotplug_status_bank dut_i (
    .clk(clk), .rstN(rstN), .blockReset(blockReset), .legacyMode(legacyMode),
    .fixedSlots(FIXED), .evtValid(evtValid), .evtBus(evtBus), .evtSlot(evtSlot),
    .evtUnplug(evtUnplug), .evtAtBoot(evtAtBoot), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady),
    .gpePulse(gpePulse), .releaseValid(releaseValid), .releaseBus(releaseBus),
    .releaseSlot(releaseSlot)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mUp[NB], mDn[NB], mMask[NB];
  logic [31:0] mSel = '0, eRdata = '0;
  int mState = 0;
  bit eGpe = 0, eRel = 0;
  int eRelBus = 0, eRelSlot = 0;

  function automatic int lowBit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) begin mUp[b] = 0; mDn[b] = 0; mMask[b] = 0; end
      mSel = 0; mState = 0; eRdata = 0; eGpe = 0; eRel = 0;
    end else begin
      bit rdy, inr, anyDn, cEn, rdClr, sEn;
      int eb, cb, cs;
      rdy = (mState == 2);
      inr = legacyMode || (mSel < NB);
      eb = legacyMode ? 0 : int'(mSel[3:0]);
      anyDn = 0;
      for (int b = 0; b < NB; b++) if (mDn[b] != 0) anyDn = 1;
      sEn = evtValid && !evtAtBoot && (evtBus < NB);
      cEn = 0; cb = 0; cs = 0;
      if (mState == 0) begin
        for (int b = NB - 1; b >= 0; b--) if (mDn[b] != 0) begin cEn = 1; cb = b; cs = lowBit(mDn[b]); end
      end else if (rdy && regWr && regAddr == 5'h08 && inr && regWdata != 0) begin
        cEn = 1; cb = eb; cs = lowBit(regWdata);
      end
      if (rdy && regRd) begin
        if (regAddr[1:0] != 0 || !inr) eRdata = 0;
        else case (regAddr)
          5'h00: eRdata = mUp[eb];
          5'h04: eRdata = mDn[eb];
          5'h0C: eRdata = mMask[eb];
          5'h10: eRdata = legacyMode ? 0 : mSel;
          default: eRdata = 0;
        endcase
      end
      rdClr = rdy && regRd && regAddr == 5'h00 && inr && !legacyMode;
      if (rdy && regWr && regAddr == 5'h10 && !legacyMode) mSel = regWdata;
      if (cEn) begin mUp[cb][cs] = 1'b0; mDn[cb][cs] = 1'b0; end
      if (rdClr) mUp[eb] = 0;
      if (sEn) begin
        if (evtUnplug) mDn[evtBus][evtSlot] = 1'b1;
        else mUp[evtBus][evtSlot] = 1'b1;
      end
      eRel = cEn && !FIXED[cb*32 + cs]; eRelBus = cb; eRelSlot = cs; eGpe = sEn;
      if (blockReset) mState = 0;
      else if (mState == 0) begin if (!anyDn) mState = 1; end
      else if (mState == 1) begin
        for (int b = 0; b < NB; b++) mMask[b] = ~FIXED[b*32 +: 32];
        mState = 2;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R1", "ready vs model", {31'b0, regReady}, {31'b0, mState == 2});
      check("R2", "gpe vs model", {31'b0, gpePulse}, {31'b0, eGpe});
      check("R6", "release vs model", {31'b0, releaseValid}, {31'b0, eRel});
      if (eRel) check("R6", "release id vs model", {23'b0, releaseBus, releaseSlot}, 32'(eRelBus*32 + eRelSlot));
      check("R4", "rdata vs model", regRdata, eRdata);
      if (logRel && releaseValid) relLog.push_back(int'(releaseBus)*32 + int'(releaseSlot));
    end
  end

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1; regAddr = a;
    @(negedge clk); regRd = 0; d = regRdata;
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask
  task automatic ev(input int bus, input int slot, input bit unp, input bit boot);
    @(negedge clk); evtValid = 1; evtBus = 4'(bus); evtSlot = 5'(slot); evtUnplug = unp; evtAtBoot = boot;
    @(negedge clk); evtValid = 0; evtAtBoot = 0;
  endtask
  task automatic waitReady();
    for (int i = 0; i < 100 && !regReady; i++) @(negedge clk);
  endtask
  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", {31'b0, regReady}, 0);
    check("R1", "rdata in reset", regRdata, 0);
    check("R1", "release in reset", {31'b0, releaseValid}, 0);
    rstN = 1;
    waitReady();
    check("R1", "ready after reset", {31'b0, regReady}, 1);
    rd(5'h0C, d); check("R7", "mask bus0 after reset", d, 32'hFFFF_FFF7);
    rd(5'h10, d); check("R1", "select after reset", d, 0);

    ev(0, 5, 0, 0); check("R2", "gpe after plug", {31'b0, gpePulse}, 1);
    rd(5'h00, d); check("R3", "insert read", d, 32'h20);
    rd(5'h00, d); check("R3", "insert cleared", d, 0);
    ev(0, 6, 0, 1); check("R2", "no gpe for boot event", {31'b0, gpePulse}, 0);
    rd(5'h00, d); check("R2", "boot event not recorded", d, 0);
    ev(4, 1, 0, 0); check("R2", "no gpe for bad bus", {31'b0, gpePulse}, 0);

    ev(2, 7, 1, 0); ev(2, 9, 1, 0);
    wr(5'h10, 2);
    rd(5'h04, d); check("R4", "remove read", d, 32'h280);
    rd(5'h04, d); check("R4", "remove kept", d, 32'h280);
    rd(5'h08, d); check("R4", "eject offset reads zero", d, 0);
    rd(5'h0C, d); check("R4", "mask bus2", d, 32'hFFFF_FFFF);
    rd(5'h10, d); check("R5", "select readback", d, 2);

    wr(5'h08, 32'h0F80);
    check("R6", "release pulse", {31'b0, releaseValid}, 1);
    check("R6", "release id", {23'b0, releaseBus, releaseSlot}, 2*32 + 7);
    rd(5'h04, d); check("R6", "remove after eject", d, 32'h200);
    wr(5'h08, 0); check("R6", "zero eject no pulse", {31'b0, releaseValid}, 0);
    rd(5'h04, d); check("R6", "zero eject no change", d, 32'h200);

    wr(5'h10, 7);
    rd(5'h04, d); check("R5", "oor remove read", d, 0);
    rd(5'h10, d); check("R5", "oor select read", d, 0);
    wr(5'h08, 32'h200); check("R5", "oor eject no pulse", {31'b0, releaseValid}, 0);
    wr(5'h10, 2);
    rd(5'h04, d); check("R5", "oor eject no change", d, 32'h200);

    @(negedge clk); evtValid = 1; evtBus = 2; evtSlot = 9; evtUnplug = 1;
    regWr = 1; regAddr = 5'h08; regWdata = 32'h200;
    @(negedge clk); evtValid = 0; regWr = 0;
    check("R8", "collision still releases", {31'b0, releaseValid}, 1);
    rd(5'h04, d); check("R8", "event bit survives eject", d, 32'h200);
    @(negedge clk); evtValid = 1; evtBus = 2; evtSlot = 4; evtUnplug = 0;
    regRd = 1; regAddr = 5'h00;
    @(negedge clk); evtValid = 0; regRd = 0;
    check("R8", "read during event", regRdata, 0);
    rd(5'h00, d); check("R8", "event bit survives read clear", d, 32'h10);

    wr(5'h10, 0);
    ev(0, 3, 1, 0);
    wr(5'h08, 32'h8); check("R6", "fixed slot no pulse", {31'b0, releaseValid}, 0);
    rd(5'h04, d); check("R6", "fixed slot bits cleared", d, 0);

    ev(1, 31, 1, 0); ev(1, 2, 1, 0); ev(3, 0, 1, 0); ev(3, 0, 0, 0);
    relLog.delete(); logRel = 1;
    @(negedge clk); blockReset = 1;
    @(negedge clk); blockReset = 0; regWr = 1; regAddr = 5'h10; regWdata = 1;
    check("R7", "ready low in drain", {31'b0, regReady}, 0);
    @(negedge clk); regWr = 0;
    waitReady(); logRel = 0;
    check("R7", "drain release count", relLog.size(), 3);
    if (relLog.size() == 3) begin
      check("R7", "drain first", relLog[0], 1*32 + 2);
      check("R7", "drain second", relLog[1], 2*32 + 9);
      check("R7", "drain third", relLog[2], 3*32 + 0);
    end
    rd(5'h10, d); check("R1", "held-off write ignored", d, 0);
    wr(5'h10, 3);
    rd(5'h00, d); check("R7", "drain cleared insert", d, 0);
    rd(5'h04, d); check("R7", "drain emptied removals", d, 0);
    wr(5'h10, 1);
    rd(5'h0C, d); check("R7", "mask rebuilt bus1", d, 32'h7FFF_FFFF);

    ev(1, 0, 1, 0);
    rd(5'h06, d); check("R10", "misaligned read zero", d, 0);
    rd(5'h14, d); check("R10", "unmapped read zero", d, 0);
    wr(5'h0A, 1); check("R10", "misaligned write no pulse", {31'b0, releaseValid}, 0);
    rd(5'h04, d); check("R10", "misaligned write no change", d, 1);

    @(negedge clk); legacyMode = 1;
    ev(0, 1, 0, 0);
    rd(5'h00, d); check("R9", "legacy insert read", d, 2);
    rd(5'h00, d); check("R9", "legacy insert kept", d, 2);
    rd(5'h10, d); check("R9", "legacy select reads zero", d, 0);
    wr(5'h10, 3);
    wr(5'h08, 32'h2);
    check("R9", "legacy eject on bus0", {27'b0, releaseValid, releaseBus}, {27'b0, 1'b1, 4'd0});
    check("R9", "legacy eject slot", {27'b0, releaseSlot}, 1);
    @(negedge clk); legacyMode = 0;
    rd(5'h10, d); check("R9", "legacy select write ignored", d, 1);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule